// File: doc/BRIEF.md
# Serial Command Relay with Delayed Host Interrupt

This block sits on a three-wire serial link (chip enable, clock, data) between a host processor and a downstream receiver chip, and runs on the receiver's 3.6 MHz system clock. Host command bytes are collected in full first. Only then is a byte sent on to the receiver, using the block's own slower serial clock. The downstream chip enable is high only while that transfer runs. Read data from the receiver goes to the host's open-drain data output through a descrambler stage. In this project that stage is a pass-through stub.

When the receiver pulls its interrupt low, the block starts a fixed setup interval of 576 system cycles (about 160 µs). At the end of the interval it pulls the host interrupt low. All host serial traffic is refused during the interval and during downstream forwarding. An active-low reset returns the block to idle. A low level on the backup input stops all activity, and the block stays stopped until it receives a reset.

Top module: `serial_relay`

## Requirements
- R1: While reset is asserted, and after it is released, the downstream chip enable and clock are low, the host interrupt is high and the host data output is released (reads 1).
- R2: Host bits are taken on each rising edge of the synchronized host clock while the host chip enable is high, least significant bit first. A byte is forwarded only once all 8 bits are in, and forwarded bytes come out in the order the host sent them.
- R3: A downstream frame keeps the chip enable high for exactly 8 bits of 8 cycles each (64 cycles). Each bit drives the clock low for 4 cycles and then high for 4. Data goes out least significant bit first and holds steady while the clock is high. The clock is high only inside a frame, and each frame starts with the clock low.
- R4: On a falling edge of the receiver interrupt, the host interrupt stays high for the setup interval. It goes low on the 579th rising clock edge after the input falls: 2 edges of synchronizer, 1 edge of detection and 576 edges of delay.
- R5: Once low, the host interrupt returns high on the 3rd rising edge after the receiver interrupt goes high.
- R6: During the setup interval, host bytes are dropped, no frame starts and the host data output is released.
- R7: While a byte is being forwarded, host clock edges are ignored. A byte shifted in during forwarding is not sent.
- R8: When idle with the host chip enable high, the host data output follows the receiver read data, with 2 cycles of synchronizer delay. Otherwise it is released (reads 1).
- R9: If a receiver interrupt fall and a host byte's final bit are detected in the same cycle, the setup interval wins and the byte is dropped.
- R10: With backup low, the block is idle: no frames, host interrupt high and host data released. After backup returns high, the block stays idle until a reset.
- R11: Dropping the host chip enable in the middle of a byte discards the partial bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.6 MHz system clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| backup_i | input | 1 | High for normal operation, low for backup (stop) |
| hce_i | input | 1 | Host serial chip enable |
| hclk_i | input | 1 | Host serial clock |
| hdat_i | input | 1 | Host serial data in |
| hdo_o | output | 1 | Host serial data out, open-drain level (1 = released) |
| hirq_no | output | 1 | Delayed interrupt to host, active low |
| dce_o | output | 1 | Downstream chip enable |
| dclk_o | output | 1 | Downstream serial clock |
| ddat_o | output | 1 | Downstream serial data |
| rx_dat_i | input | 1 | Read data from receiver |
| rx_irq_ni | input | 1 | Interrupt from receiver, falling edge active |

## Verification
A receiver interrupt fall and the final host clock rise of a byte can be detected in the same cycle. The bench provokes this by driving both inputs at the same falling clock edge. Because both pass through identical synchronizers, the detection lands in one cycle. The design is correct if no downstream frame ever appears for that byte and the host interrupt still falls 579 edges after the receiver interrupt.

// File: rtl/relay_pkg.sv
package relay_pkg;
  localparam int unsigned RELAY_BITS   = 8;
  localparam int unsigned RELAY_CLK_LO = 4;
  localparam int unsigned RELAY_CLK_HI = 4;
  localparam int unsigned RELAY_DELAY  = 576;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/relay_sync.sv
module relay_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/relay_host_rx.sv
module relay_host_rx #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            ce_i,
  input  logic            sclk_i,
  input  logic            sdat_i,
  output logic            vld_o,
  output logic [BITS-1:0] byte_o
);
  localparam int unsigned BW = $clog2(BITS);
  localparam logic [BW-1:0] LAST = BW'(BITS - 1);

  logic            sclk_q;
  logic [BW-1:0]   cnt_q;
  logic [BITS-2:0] sh_q;
  logic            rise;

  assign rise = sclk_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      if (!accept_i || !ce_i) begin
        cnt_q <= '0;
      end else if (rise) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        sh_q  <= {sdat_i, sh_q[BITS-2:1]};
      end
    end
  end

  // lsb arrives first, so the newest bit lands on top
  assign vld_o  = accept_i & ce_i & rise & (cnt_q == LAST);
  assign byte_o = {sdat_i, sh_q};
endmodule

// File: rtl/relay_down_tx.sv
module relay_down_tx
  import relay_pkg::*;
#(
  parameter int unsigned BITS   = 8,
  parameter int unsigned CLK_LO = 4,
  parameter int unsigned CLK_HI = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            load_i,
  input  logic [BITS-1:0] byte_i,
  output logic            busy_o,
  output logic            sclk_o,
  output logic            sdat_o
);
  localparam int unsigned PW = $clog2(CLK_LO + CLK_HI);
  localparam int unsigned BW = $clog2(BITS);
  localparam logic [PW-1:0] PH_LAST = PW'(CLK_LO + CLK_HI - 1);
  localparam logic [PW-1:0] PH_HI   = PW'(CLK_LO);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);

  tx_state_e       st_q;
  logic [PW-1:0]   ph_q;
  logic [BW-1:0]   bit_q;
  logic [BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= TX_IDLE;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else if (!run_i) begin
      st_q  <= TX_IDLE;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (load_i) begin
          st_q  <= TX_SEND;
          sh_q  <= byte_i;
          ph_q  <= '0;
          bit_q <= '0;
        end
        TX_SEND: if (ph_q == PH_LAST) begin
          ph_q <= '0;
          sh_q <= sh_q >> 1;
          if (bit_q == BIT_LAST) st_q <= TX_IDLE;
          else bit_q <= bit_q + 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == TX_SEND);
  assign sclk_o = busy_o & (ph_q >= PH_HI);
  assign sdat_o = busy_o & sh_q[0];
endmodule

// File: rtl/relay_irq_timer.sv
module relay_irq_timer #(
  parameter int unsigned DELAY = 576
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic irq_s_i,
  output logic fall_o,
  output logic lock_o,
  output logic hirq_no
);
  localparam int unsigned CW = $clog2(DELAY);
  localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

  logic          prev_q, lock_q, irq_q;
  logic [CW-1:0] cnt_q;

  assign fall_o = run_i & prev_q & ~irq_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      lock_q <= 1'b0;
      irq_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (!run_i) begin
      prev_q <= irq_s_i;
      lock_q <= 1'b0;
      irq_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= irq_s_i;
      if (lock_q) begin
        if (cnt_q == '0) begin
          lock_q <= 1'b0;
          irq_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (fall_o) begin
        lock_q <= 1'b1;
        cnt_q  <= LOAD;
        irq_q  <= 1'b1;
      end else if (!irq_q && irq_s_i) begin
        irq_q <= 1'b1;
      end
    end
  end

  assign lock_o  = lock_q;
  assign hirq_no = irq_q;
endmodule

// File: rtl/relay_descr_stub.sv
module relay_descr_stub (
  input  logic d_i,
  output logic d_o
);
  assign d_o = d_i;
endmodule

// File: rtl/serial_relay.sv
module serial_relay
  import relay_pkg::*;
#(
  parameter int unsigned BITS   = RELAY_BITS,
  parameter int unsigned CLK_LO = RELAY_CLK_LO,
  parameter int unsigned CLK_HI = RELAY_CLK_HI,
  parameter int unsigned DELAY  = RELAY_DELAY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic backup_i,
  input  logic hce_i,
  input  logic hclk_i,
  input  logic hdat_i,
  output logic hdo_o,
  output logic hirq_no,
  output logic dce_o,
  output logic dclk_o,
  output logic ddat_o,
  input  logic rx_dat_i,
  input  logic rx_irq_ni
);
  logic            halt_q, run_w;
  logic [4:0]      sync_w;
  logic            hce_s, hclk_s, hdat_s, rxirq_s, rxdat_s;
  logic            lock_w, fall_w, busy_w, accept_w, vld_w;
  logic [BITS-1:0] byte_w;
  logic            rd_w;

  // leaving backup needs a reset before resuming
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        halt_q <= 1'b0;
    else if (!backup_i) halt_q <= 1'b1;
  end
  assign run_w = backup_i & ~halt_q;

  relay_sync #(.W(5), .RST(5'b00011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hce_i, hclk_i, hdat_i, rx_irq_ni, rx_dat_i}),
    .q_o   (sync_w)
  );
  assign {hce_s, hclk_s, hdat_s, rxirq_s, rxdat_s} = sync_w;

  relay_irq_timer #(.DELAY(DELAY)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .irq_s_i(rxirq_s),
    .fall_o (fall_w),
    .lock_o (lock_w),
    .hirq_no(hirq_no)
  );

  // lockout start beats a byte completing in the same cycle
  assign accept_w = run_w & ~lock_w & ~fall_w & ~busy_w;

  relay_host_rx #(.BITS(BITS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept_w),
    .ce_i    (hce_s),
    .sclk_i  (hclk_s),
    .sdat_i  (hdat_s),
    .vld_o   (vld_w),
    .byte_o  (byte_w)
  );

  relay_down_tx #(.BITS(BITS), .CLK_LO(CLK_LO), .CLK_HI(CLK_HI)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_w),
    .load_i(vld_w),
    .byte_i(byte_w),
    .busy_o(busy_w),
    .sclk_o(dclk_o),
    .sdat_o(ddat_o)
  );
  assign dce_o = busy_w;

  relay_descr_stub u_descr (
    .d_i(rxdat_s),
    .d_o(rd_w)
  );

  assign hdo_o = ~(run_w & ~lock_w & ~busy_w & hce_s & ~rd_w);
endmodule

// File: rtl/serial_relay_chk.sv
module serial_relay_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dce_o,
  input logic dclk_o,
  input logic hirq_no,
  input logic hdo_o,
  input logic lock_i,
  input logic run_i
);
  p_dclk_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dclk_o |-> dce_o);

  p_frame_starts_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dce_o) |-> !dclk_o);

  p_irq_high_in_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> hirq_no);

  p_hdo_released_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> hdo_o);

  p_no_start_in_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dce_o) |-> !$past(lock_i));

  p_halt_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!dce_o && hirq_no && hdo_o));
endmodule

bind serial_relay serial_relay_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .dce_o  (dce_o),
  .dclk_o (dclk_o),
  .hirq_no(hirq_no),
  .hdo_o  (hdo_o),
  .lock_i (lock_w),
  .run_i  (run_w)
);

// File: tb/sim_serial_relay.sv
`timescale 1ns/1ps
module sim_serial_relay;
  localparam int LO = 4, HI = 4, DELAY = 576;

  logic clk = 1'b0, rst_n = 1'b0, backup = 1'b1;
  logic hce = 1'b0, hclk = 1'b0, hdat = 1'b0, rx_dat = 1'b1, rx_irq_n = 1'b1;
  logic hdo, hirq_n, dce, dclk, ddat;

  serial_relay #(.BITS(8), .CLK_LO(LO), .CLK_HI(HI), .DELAY(DELAY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .backup_i(backup),
    .hce_i(hce), .hclk_i(hclk), .hdat_i(hdat),
    .hdo_o(hdo), .hirq_no(hirq_n),
    .dce_o(dce), .dclk_o(dclk), .ddat_o(ddat),
    .rx_dat_i(rx_dat), .rx_irq_ni(rx_irq_n)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string phase = "R1";
  bit model_on = 0;
  int since_fall = -1, since_rise = -1;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // interrupt reference model: edge counts since the input changed
  always @(posedge clk) begin
    if (since_fall >= 0) since_fall++;
    if (since_rise >= 0) since_rise++;
  end

  always @(negedge clk) begin
    if (model_on) begin
      int e;
      e = (since_fall >= DELAY + 3 && !(since_rise >= 3)) ? 0 : 1;
      check("R4 or R5", "host irq vs model", hirq_n, e);
    end
  end

  // downstream frame monitor
  logic prev_dce = 0, prev_clk = 0;
  int low_cnt = 0, nbits = 0, flen = 0;
  logic [7:0] bits = '0;
  always @(negedge clk) begin
    if (dce) begin
      flen++;
      if (!dclk) low_cnt++;
      if (dclk && !prev_clk) begin
        check("R3", "clock low phase", low_cnt, LO);
        low_cnt = 0;
        if (nbits < 8) bits[nbits] = ddat;
        nbits++;
      end
    end
    if (!dce && prev_dce) begin
      check("R3", "frame length", flen, 8 * (LO + HI));
      check("R3", "bits per frame", nbits, 8);
      if (exp_q.size() == 0) check(phase, "unexpected frame", int'(bits), -1);
      else check("R2", "forwarded byte", int'(bits), int'(exp_q.pop_front()));
      flen = 0; nbits = 0; low_cnt = 0;
    end
    prev_dce = dce;
    prev_clk = dclk;
  end

  task automatic send_bits(input logic [7:0] b, input int n, input int half, input bit push);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) hdat = b[i];
      repeat (half) @(negedge clk);
      hclk = 1'b1;
      if (push && i == 7) exp_q.push_back(b);
      repeat (half) @(negedge clk);
      hclk = 1'b0;
    end
  endtask

  task automatic host_on();
    @(negedge clk) hce = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_off();
    @(negedge clk) hce = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic irq_fall();
    @(negedge clk) rx_irq_n = 1'b0;
    since_fall = 0; since_rise = -1;
  endtask

  task automatic irq_rise();
    @(negedge clk) rx_irq_n = 1'b1;
    since_rise = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=200000 cycles expected=run to end");
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "dce in reset", dce, 0);
    check("R1", "dclk in reset", dclk, 0);
    check("R1", "hirq in reset", hirq_n, 1);
    check("R1", "hdo in reset", hdo, 1);
    rst_n = 1'b1;
    model_on = 1;
    repeat (3) @(negedge clk);
    check("R1", "dce after reset", dce, 0);
    check("R1", "hdo after reset", hdo, 1);

    // R2, R3 ordered bytes
    phase = "R2";
    host_on();
    send_bits(8'hA5, 8, 4, 1);
    host_off();
    repeat (90) @(negedge clk);
    host_on();
    send_bits(8'h3C, 8, 4, 1);
    host_off();
    repeat (90) @(negedge clk);
    host_on();
    send_bits(8'h01, 8, 4, 1);
    host_off();
    repeat (90) @(negedge clk);

    // R8 read pass-through
    phase = "R8";
    host_on();
    @(negedge clk) rx_dat = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "hdo follows 0", hdo, 0);
    rx_dat = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", "hdo follows 1", hdo, 1);
    rx_dat = 1'b0;
    host_off();
    check("R8", "hdo released with ce low", hdo, 1);
    rx_dat = 1'b1;

    // R11 partial byte discarded
    phase = "R11";
    host_on();
    send_bits(8'hF0, 4, 4, 0);
    host_off();
    host_on();
    send_bits(8'h69, 8, 4, 1);
    host_off();
    repeat (90) @(negedge clk);

    // R7 byte during forwarding dropped
    phase = "R7";
    host_on();
    send_bits(8'h80, 8, 4, 1);
    send_bits(8'hFF, 8, 2, 0);
    host_off();
    repeat (90) @(negedge clk);

    // R4, R5, R6 lockout
    phase = "R6";
    irq_fall();
    repeat (10) @(negedge clk);
    rx_dat = 1'b0;
    host_on();
    check("R6", "hdo released in lockout", hdo, 1);
    send_bits(8'h5A, 8, 4, 0);
    host_off();
    rx_dat = 1'b1;
    while (since_fall < DELAY + 2) @(negedge clk);
    check("R4", "hirq before delay end", hirq_n, 1);
    @(negedge clk);
    check("R4", "hirq at delay end", hirq_n, 0);
    repeat (5) @(negedge clk);
    irq_rise();
    repeat (2) @(negedge clk);
    check("R5", "hirq 2 edges after rise", hirq_n, 0);
    @(negedge clk);
    check("R5", "hirq 3 edges after rise", hirq_n, 1);
    repeat (20) @(negedge clk);

    // R9 irq fall and final bit in the same cycle
    phase = "R9";
    host_on();
    send_bits(8'h96, 7, 4, 0);
    @(negedge clk) hdat = 1'b1;
    repeat (4) @(negedge clk);
    hclk = 1'b1;
    rx_irq_n = 1'b0;
    since_fall = 0; since_rise = -1;
    repeat (4) @(negedge clk);
    hclk = 1'b0;
    host_off();
    while (since_fall < DELAY + 3) @(negedge clk);
    check("R9", "lockout still timed", hirq_n, 0);
    irq_rise();
    repeat (20) @(negedge clk);

    // R10 backup stop and reset required
    phase = "R10";
    @(negedge clk) backup = 1'b0;
    rx_dat = 1'b0;
    host_on();
    check("R10", "dce in backup", dce, 0);
    check("R10", "hdo in backup", hdo, 1);
    check("R10", "hirq in backup", hirq_n, 1);
    @(negedge clk) backup = 1'b1;
    repeat (3) @(negedge clk);
    send_bits(8'hC3, 8, 4, 0);
    check("R10", "hdo still halted", hdo, 1);
    host_off();
    rx_dat = 1'b1;
    repeat (80) @(negedge clk);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    phase = "R2";
    host_on();
    send_bits(8'hC3, 8, 4, 1);
    host_off();
    repeat (100) @(negedge clk);

    check("R2", "frames outstanding", exp_q.size(), 0);
    summary();
  end
endmodule